// File: doc/BRIEF.md
# Lockable Watchdog Timer with Pretimeout

This block is a system watchdog with a small 16-bit register file. A 2 Hz tick enable, supplied from outside, decrements a down-counter whose start value comes from an 8-bit timeout field in the control register. Software keeps the system alive by writing two key values in a row to the service register. Each valid key pair reloads the counter. If the counter reaches zero, the block records a timeout cause and pulses a reset-request output for one cycle.

Several control fields can be written only once between resets, so stray writes cannot disarm a running watchdog. An optional pretimeout stage can raise a level interrupt a programmable number of ticks before expiry. This warns software before the reset fires. Software can also request a reset directly through the control register. The recorded reset cause stays readable until the next reset.

Register offsets on `addr_i` are: 0 control, 1 service, 2 reset cause, 3 interrupt control, 4 misc. Offsets 5 to 7 are unmapped.

Top module: `wdog_top`

## Requirements
- R1: Out of reset the registers read as follows: control 0x0006, service 0x0000, cause 0x0000, interrupt control 0x0004 (the PRE_DEF default) and misc 0x0001. `rst_req_o` and `irq_o` are low.
- R2: The control register layout is: bit 0 enable, bit 1 software-reset bar, bit 2 external-assert bar, bits [15:8] timeout. A write that leaves enable set with a nonzero timeout T loads the counter with T+1. After T+1 ticks the counter expires. On expiry `rst_req_o` pulses once and the cause register reads 0x0002 (bit 1, timeout only).
- R3: The counter does not count while enable is 0 or the timeout field is 0. No ticks then lead to a reset request.
- R4: A service write of 0xAAAA reloads the counter to T+1, but only when the previous service write was 0x5555. Any other order does not reload. The service register reads back the last value written.
- R5: Once enable has been written as 1, later control writes cannot clear it until reset.
- R6: After the first control write, the timeout field keeps its value on every later control write.
- R7: A control write with bit 1 at 0 sets the cause register to 0x0001 (bit 0, software only) and pulses `rst_req_o`. Control bit 1 always reads as 1.
- R8: A control write also pulses `rst_req_o` in two other cases. One is when bit 2 is written as 0. The other is when the resulting enable is 1 and the resulting timeout field is 0. Neither case changes the cause register.
- R9: The interrupt control layout is: bit 15 interrupt enable, bit 14 status, bits [7:0] pretimeout value P. The pretimeout is armed on a control write, a valid service reload or an interrupt-control write. It is armed only if the counter runs, bit 15 is set and the remaining count C is greater than P. It then fires after C-P ticks: bit 14 sets and `irq_o` goes high. If C <= P, it never fires.
- R10: Writing 1 to interrupt-control bit 14 clears the status and drops `irq_o`.
- R11: After the first interrupt-control write, bits 15 and [7:0] keep their values. Only the bit 14 clear still acts.
- R12: The misc register stores only bit 0. Its other bits read as 0.
- R13: Reads of offsets 5 to 7 return 0. Writes to the cause register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Half-second tick enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| irq_o | output | 1 | Pretimeout interrupt, level |

## Verification
The bench tests the service key order. It uses a valid pair, and an intruding write between the keys. A design that only compared the current key would reload on the broken sequence and miss the expected reset. It tests the write-once fields by trying to clear enable and to zero the timeout after the first write. A leaky lock would either stop the counter or raise a spurious zero-timeout reset. It tests the pretimeout against the count boundary with two cases: a value below the loaded count, where the interrupt must fire exactly C-P ticks in, and a value above it, where no interrupt may appear. An off-by-one in the reload, or in the arm check, shifts the expiry tick or raises a stray interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;
  localparam int TO_W = 8;
  localparam int TO_LSB = 8;
  localparam int PRE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_SVC   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_INTC  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MISC  = 3'd4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_SRS = 1;
  localparam int CTRL_WDA = 2;

  localparam int INTC_IEN = 15;
  localparam int INTC_STS = 14;

  localparam logic [1:0] CAUSE_SW = 2'b01;
  localparam logic [1:0] CAUSE_TO = 2'b10;

  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;
endpackage

// File: rtl/wdog_dcnt.sv
module wdog_dcnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (tick_i && cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == W'(1));
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] last_o,
  output logic             reload_o
);
  logic [REG_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= '0;
    else if (wr_i) last_q <= data_i;
  end

  // key pair must be back to back on the service offset
  assign reload_o = wr_i && (last_q == KEY_FIRST) && (data_i == KEY_SECOND);
  assign last_o   = last_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter logic [PRE_W-1:0] PRE_DEF = 8'd4,
  parameter bit               PRE_EN  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  localparam int CNT_W = TO_W + 1;

  logic              en_q, wda_q, ctrl_seen_q;
  logic [TO_W-1:0]   to_q;
  logic              pde_q;
  logic [1:0]        cause_q;
  logic              rst_req_q;
  logic              ien_q, sts_q, intc_lock_q;
  logic [PRE_W-1:0]  pre_q;
  logic              pre_done;

  logic wr_ctrl, wr_svc, wr_intc, wr_misc;
  assign wr_ctrl = wr_en_i && addr_i == OFF_CTRL;
  assign wr_svc  = wr_en_i && addr_i == OFF_SVC;
  assign wr_intc = wr_en_i && addr_i == OFF_INTC && PRE_EN;
  assign wr_misc = wr_en_i && addr_i == OFF_MISC;

  // control write: effective values after locking
  logic [TO_W-1:0] to_nx;
  logic            en_nx, wda_nx, srs_wr, run_nx, run_now, ctrl_req;
  assign to_nx   = ctrl_seen_q ? to_q : wdata_i[TO_LSB +: TO_W];
  assign en_nx   = en_q | wdata_i[CTRL_EN];
  assign wda_nx  = wdata_i[CTRL_WDA];
  assign srs_wr  = wdata_i[CTRL_SRS];
  assign run_nx  = en_nx && to_nx != '0;
  assign run_now = en_q && to_q != '0;
  assign ctrl_req = wr_ctrl && (!srs_wr || !wda_nx || (en_nx && to_nx == '0));

  logic [REG_W-1:0] svc_last;
  logic             svc_reload;

  wdog_svc i_svc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_svc),
    .data_i   (wdata_i),
    .last_o   (svc_last),
    .reload_o (svc_reload)
  );

  logic             m_load, main_done;
  logic [CNT_W-1:0] m_val, cnt_main;
  assign m_load = wr_ctrl || (svc_reload && run_now);
  assign m_val  = wr_ctrl ? (run_nx ? {1'b0, to_nx} + 1'b1 : '0)
                          : {1'b0, to_q} + 1'b1;

  wdog_dcnt #(.W(CNT_W)) i_main_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (m_load),
    .load_val_i (m_val),
    .cnt_o      (cnt_main),
    .done_o     (main_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      wda_q       <= 1'b1;
      to_q        <= '0;
      ctrl_seen_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q        <= en_nx;
      wda_q       <= wda_nx;
      to_q        <= to_nx;
      ctrl_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q   <= '0;
      rst_req_q <= 1'b0;
      pde_q     <= 1'b1;
    end else begin
      rst_req_q <= ctrl_req | (main_done & en_q);
      if (main_done)              cause_q <= CAUSE_TO;
      if (wr_ctrl && !srs_wr)     cause_q <= CAUSE_SW;
      if (wr_misc)                pde_q   <= wdata_i[0];
    end
  end

  generate
    if (PRE_EN) begin : g_pre
      logic             ien_eff, p_run, p_load;
      logic [PRE_W-1:0] pre_eff;
      logic [CNT_W-1:0] p_base, p_val;

      assign ien_eff = (wr_intc && !intc_lock_q) ? wdata_i[INTC_IEN] : ien_q;
      assign pre_eff = (wr_intc && !intc_lock_q) ? wdata_i[PRE_W-1:0] : pre_q;
      assign p_base  = m_load ? m_val : cnt_main;
      assign p_run   = m_load ? (m_val != '0) : (run_now && cnt_main != '0);
      assign p_load  = m_load || wr_intc;
      assign p_val   = (p_run && ien_eff && p_base > CNT_W'(pre_eff))
                       ? p_base - CNT_W'(pre_eff) : '0;

      logic [CNT_W-1:0] cnt_pre;
      wdog_dcnt #(.W(CNT_W)) i_pre_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (p_load),
        .load_val_i (p_val),
        .cnt_o      (cnt_pre),
        .done_o     (pre_done)
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ien_q       <= 1'b0;
          pre_q       <= PRE_DEF;
          intc_lock_q <= 1'b0;
          sts_q       <= 1'b0;
        end else begin
          if (wr_intc) begin
            ien_q       <= ien_eff;
            pre_q       <= pre_eff;
            intc_lock_q <= 1'b1;
          end
          if (pre_done)                             sts_q <= 1'b1;
          else if (wr_intc && wdata_i[INTC_STS])    sts_q <= 1'b0;
        end
      end
    end else begin : g_no_pre
      assign ien_q       = 1'b0;
      assign pre_q       = PRE_DEF;
      assign intc_lock_q = 1'b0;
      assign sts_q       = 1'b0;
      assign pre_done    = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:  rdata_o = {to_q, 5'b0, wda_q, 1'b1, en_q};
      OFF_SVC:   rdata_o = svc_last;
      OFF_CAUSE: rdata_o = {14'b0, cause_q};
      OFF_INTC:  rdata_o = {ien_q, sts_q, 6'b0, pre_q};
      OFF_MISC:  rdata_o = {15'b0, pde_q};
      default:   rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = sts_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic              en_q,
  input logic              ctrl_seen_q,
  input logic [TO_W-1:0]   to_q,
  input logic [CNT_W-1:0]  cnt_main,
  input logic [REG_W-1:0]  svc_last,
  input logic              pre_done
);
  // R5
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);

  // R6
  to_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_seen_q |=> $stable(to_q));

  // R4
  svc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SVC && wdata_i == KEY_SECOND &&
     svc_last == KEY_FIRST && en_q && to_q != '0)
    |=> (cnt_main - 1'b1) == {1'b0, $past(to_q)});

  // R3
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q || to_q == '0) |-> cnt_main == '0);

  // R13
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > OFF_MISC) |-> rdata_o == '0);

  // R12
  misc_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_MISC) |-> rdata_o[REG_W-1:1] == '0);

  // R10
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_INTC && wdata_i[INTC_STS] && !pre_done) |=> !irq_o);
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) i_wdog_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .ctrl_seen_q (ctrl_seen_q),
  .to_q        (to_q),
  .cnt_main    (cnt_main),
  .svc_last    (svc_last),
  .pre_done    (pre_done)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req, irq;

  int n_chk = 0, n_fail = 0;
  int req_n = 0, req_base = 0;

  always #4 clk = ~clk;

  wdog_top i_wdog_top (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .rst_req_o (rst_req),
    .irq_o     (irq)
  );

  always @(negedge clk) if (rst_req) req_n++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    req_base = req_n;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_req(input string req, input int exp);
    chk(req, 16'(req_n - req_base), 16'(exp));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    rd(3'd0, d); chk("R1 ctrl", d, 16'h0006);
    rd(3'd1, d); chk("R1 svc", d, 16'h0000);
    rd(3'd2, d); chk("R1 cause", d, 16'h0000);
    rd(3'd3, d); chk("R1 intc", d, 16'h0004);
    rd(3'd4, d); chk("R1 misc", d, 16'h0001);
    chk("R1 outputs", {14'b0, rst_req, irq}, 16'h0);
  endtask

  task automatic t_expire();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0307);
    ticks(3); chk_req("R2 before expiry", 0);
    ticks(1); chk_req("R2 expiry pulse", 1);
    rd(3'd2, d); chk("R2 cause", d, 16'h0002);
  endtask

  task automatic t_idle();
    do_reset();
    wr(3'd0, 16'h0006);
    ticks(3); chk_req("R3 zero timeout idle", 0);
    do_reset();
    wr(3'd0, 16'h0306);
    ticks(6); chk_req("R3 disabled idle", 0);
  endtask

  task automatic t_lock_to();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0306);
    wr(3'd0, 16'h0007);
    rd(3'd0, d); chk("R6 timeout kept", d, 16'h0307);
    chk_req("R6 no zero-timeout request", 0);
    ticks(4); chk_req("R6 runs with kept timeout", 1);
  endtask

  task automatic t_en_sticky();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0307);
    wr(3'd0, 16'h0306);
    rd(3'd0, d); chk("R5 enable sticky", d, 16'h0307);
  endtask

  task automatic t_service();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0307);
    ticks(2);
    wr(3'd1, 16'h5555); wr(3'd1, 16'hAAAA);
    rd(3'd1, d); chk("R4 svc readback", d, 16'hAAAA);
    ticks(3); chk_req("R4 reloaded no expiry", 0);
    ticks(1); chk_req("R4 expiry after reload", 1);
    do_reset();
    wr(3'd0, 16'h0307);
    ticks(2);
    wr(3'd1, 16'h5555); wr(3'd1, 16'h1234); wr(3'd1, 16'hAAAA);
    ticks(2); chk_req("R4 broken sequence no reload", 1);
  endtask

  task automatic t_swrst();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0004);
    repeat (2) @(negedge clk);
    chk_req("R7 sw request", 1);
    rd(3'd2, d); chk("R7 sw cause", d, 16'h0001);
    rd(3'd0, d); chk("R7 srs reads 1", d, 16'h0006);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, d); chk("R13 cause write ignored", d, 16'h0001);
    rd(3'd5, d); chk("R13 unmapped 5", d, 16'h0000);
    rd(3'd7, d); chk("R13 unmapped 7", d, 16'h0000);
  endtask

  task automatic t_other_req();
    logic [15:0] d;
    do_reset();
    wr(3'd0, 16'h0002);
    repeat (2) @(negedge clk);
    chk_req("R8 assert bit cleared", 1);
    rd(3'd2, d); chk("R8 cause unchanged", d, 16'h0000);
    do_reset();
    wr(3'd0, 16'h0007);
    repeat (2) @(negedge clk);
    chk_req("R8 enable with zero timeout", 1);
    rd(3'd2, d); chk("R8 cause unchanged zero", d, 16'h0000);
  endtask

  task automatic t_pre();
    logic [15:0] d;
    do_reset();
    wr(3'd3, 16'h8002);
    wr(3'd0, 16'h0507);
    ticks(3); chk("R9 no irq early", {15'b0, irq}, 16'h0);
    ticks(1); chk("R9 irq at C-P", {15'b0, irq}, 16'h1);
    rd(3'd3, d); chk("R9 status set", d, 16'hC002);
    wr(3'd3, 16'h4000);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);
    rd(3'd3, d); chk("R11 intc locked", d, 16'h8002);
    chk_req("R9 no reset yet", 0);
    ticks(2); chk_req("R9 main expiry", 1);
    do_reset();
    wr(3'd3, 16'h8007);
    wr(3'd0, 16'h0307);
    ticks(4);
    chk("R9 not armed when C<=P", {15'b0, irq}, 16'h0);
    chk_req("R9 expiry without irq", 1);
  endtask

  task automatic t_misc();
    logic [15:0] d;
    do_reset();
    wr(3'd4, 16'hFFFE);
    rd(3'd4, d); chk("R12 misc clear", d, 16'h0000);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, d); chk("R12 misc only bit0", d, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_expire();
    t_idle();
    t_lock_to();
    t_en_sticky();
    t_service();
    t_swrst();
    t_other_req();
    t_pre();
    t_misc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule